// File: doc/BRIEF.md
# Pulse-Count Boot Interface Selector

This block picks which serial link an external programmer will use to load on-chip non-volatile memory. While the chip's reset pin is held low and programming entry is enabled, the programmer toggles the programming-supply level a chosen number of times. A comparator outside this block turns that supply level into a digital "supply is high" signal. The block counts the clean rising edges of that signal. When the reset pin is released, it turns the final count into a protocol-and-channel choice.

The result is an encoded mode, a one-hot select for the serial channel whose pins are handed to the programmer, and a select for a software-driven mode that uses general port pins. A valid flag reports a legal count and an error flag reports any other count. All of these hold until the reset pin is asserted again. Short supply glitches are filtered out, and the counter saturates so that too many pulses cannot alias onto a legal code.

The block has its own asynchronous register reset (`arst_n`). It is separate from the sampled reset pin (`rst_pin_n`), so the logic keeps counting while the chip is held in reset.

Top module: `prog_iface_select`

## Requirements
- R1: A rising edge of `vpp_high` counts once only when the input stays high for at least FILT_LEN clocks (default 4). A high level shorter than that is not counted. Pulses count only while `rst_pin_n` is low and `prog_en` is high.
- R2: When the latched count is legal, `mode_o` takes these codes: 0 pulses gives 0 (3-wire serial, channel 0); 1 gives 1 (3-wire serial, channel 1); 2 gives 2 (3-wire serial, channel 2); 4 gives 3 (two-wire I2C on channel 0); 8 gives 4 (UART, channel 1); 9 gives 5 (UART, channel 2); 12 gives 6 (software-driven 3-wire on port pins). `mode_valid_o` is 1 in each of these cases.
- R3: Any other count sets `mode_error_o`=1 and `mode_valid_o`=0, with `mode_o`=7 (none), `chan_sel_o`=0 and `gpio_sel_o`=0.
- R4: The pulse counter saturates at 15. Sixteen or more pulses therefore give the R3 error and never a legal code.
- R5: The count is decoded and latched when `rst_pin_n` rises, and the outputs show the result within 4 clocks. While `rst_pin_n` stays high, the outputs hold and `vpp_high` has no effect on them.
- R6: Driving `rst_pin_n` low clears `mode_valid_o` and `mode_error_o` and sets `mode_o` to 7 within 4 clocks. Each reset period counts from zero.
- R7: `chan_sel_o` is one-hot or zero. Bit 0 is set for codes 0 and 3, bit 1 for codes 1 and 4, and bit 2 for codes 2 and 5. `gpio_sel_o` is 1 only for code 6.
- R8: If `prog_en` is low when `rst_pin_n` rises, the outputs show `mode_valid_o`=0, `mode_error_o`=0 and `mode_o`=7, whatever pulses were applied.
- R9: While `arst_n` is low, the outputs are `mode_o`=7 with every flag and select at 0.
- R10: `mode_valid_o` and `mode_error_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| arst_n | input | 1 | Asynchronous active-low register reset |
| rst_pin_n | input | 1 | Chip reset pin level, active low (synchronized inside) |
| vpp_high | input | 1 | Comparator output, 1 when the programming supply is high (synchronized inside) |
| prog_en | input | 1 | Programming entry enable |
| mode_o | output | 3 | Encoded boot interface; 7 means none |
| mode_valid_o | output | 1 | The latched count was legal |
| mode_error_o | output | 1 | The latched count was not legal |
| chan_sel_o | output | 3 | One-hot serial channel handed to the programmer |
| gpio_sel_o | output | 1 | Software-driven port-pin mode selected |

## Verification
A counter state off by one moves the latched count onto a neighbouring code. That shows at the ports at the first release after the error, as a wrong `mode_o` or `chan_sel_o`, or as an error flag where a valid one belongs. The sweep over every pulse count from 0 to 16 catches this within one boot sequence. A filter that passes too much or too little shows up as a count one higher or lower in the glitch and width-boundary sequences. A latch that fails to hold shows up as a change in the outputs during the pulses applied after release.

// File: rtl/psel_pkg.sv
package psel_pkg;

  localparam int NUM_CH = 3;

  typedef enum logic [2:0] {
    BM_SYNC_CH0 = 3'd0,
    BM_SYNC_CH1 = 3'd1,
    BM_SYNC_CH2 = 3'd2,
    BM_TWI_CH0  = 3'd3,
    BM_UART_CH1 = 3'd4,
    BM_UART_CH2 = 3'd5,
    BM_SOFT_3W  = 3'd6,
    BM_NONE     = 3'd7
  } boot_mode_e;

  // Serial channel whose pins a mode uses; NUM_CH means no channel.
  function automatic int chan_of(boot_mode_e m);
    case (m)
      BM_SYNC_CH0, BM_TWI_CH0:  return 0;
      BM_SYNC_CH1, BM_UART_CH1: return 1;
      BM_SYNC_CH2, BM_UART_CH2: return 2;
      default:                  return NUM_CH;
    endcase
  endfunction

endpackage

// File: rtl/psel_sync.sv
module psel_sync #(
  parameter int             W       = 1,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;

endmodule

// File: rtl/psel_glitch_filter.sv
module psel_glitch_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic arst_n,
  input  logic din_i,
  output logic rise_o
);

  localparam int             FW   = $clog2(FILT_LEN + 1);
  localparam logic [FW-1:0]  LAST = FW'(FILT_LEN - 1);

  logic          lvl_q, lvl_d;
  logic [FW-1:0] run_q, run_d;

  // The accepted level flips only after FILT_LEN clocks of disagreement.
  always_comb begin
    lvl_d  = lvl_q;
    run_d  = '0;
    rise_o = 1'b0;
    if (din_i != lvl_q) begin
      if (run_q == LAST) begin
        lvl_d  = din_i;
        rise_o = din_i;
      end else begin
        run_d = run_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      lvl_q <= 1'b0;
      run_q <= '0;
    end else begin
      lvl_q <= lvl_d;
      run_q <= run_d;
    end
  end

endmodule

// File: rtl/psel_pulse_counter.sv
module psel_pulse_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (en_i && inc_i && (cnt_q != CNT_MAX)) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/psel_mode_decode.sv
module psel_mode_decode
  import psel_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic [CNT_W-1:0]  cnt_i,
  output boot_mode_e        mode_o,
  output logic              legal_o,
  output logic [NUM_CH-1:0] chan_sel_o,
  output logic              gpio_sel_o
);

  always_comb begin
    case (cnt_i)
      CNT_W'(0):  mode_o = BM_SYNC_CH0;
      CNT_W'(1):  mode_o = BM_SYNC_CH1;
      CNT_W'(2):  mode_o = BM_SYNC_CH2;
      CNT_W'(4):  mode_o = BM_TWI_CH0;
      CNT_W'(8):  mode_o = BM_UART_CH1;
      CNT_W'(9):  mode_o = BM_UART_CH2;
      CNT_W'(12): mode_o = BM_SOFT_3W;
      default:    mode_o = BM_NONE;
    endcase
  end

  assign legal_o    = (mode_o != BM_NONE);
  assign gpio_sel_o = (mode_o == BM_SOFT_3W);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    assign chan_sel_o[c] = (chan_of(mode_o) == c);
  end

endmodule

// File: rtl/prog_iface_select.sv
module prog_iface_select
  import psel_pkg::*;
#(
  parameter int FILT_LEN = 4,
  parameter int CNT_W    = 4
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              rst_pin_n,
  input  logic              vpp_high,
  input  logic              prog_en,
  output logic [2:0]        mode_o,
  output logic              mode_valid_o,
  output logic              mode_error_o,
  output logic [NUM_CH-1:0] chan_sel_o,
  output logic              gpio_sel_o
);

  logic [1:0]        sync_q;
  logic              rst_s, vpp_s, rst_prev_q;
  logic              rise, count_en, count_clr;
  logic              release_edge, assert_edge;
  logic [CNT_W-1:0]  pulse_cnt;
  boot_mode_e        dec_mode;
  logic              dec_legal, dec_gpio;
  logic [NUM_CH-1:0] dec_chan;

  boot_mode_e        mode_q, mode_d;
  logic              valid_q, valid_d, error_q, error_d, gpio_q, gpio_d;
  logic [NUM_CH-1:0] chan_q, chan_d;

  // bit 0: reset pin (idles released), bit 1: supply sense
  psel_sync #(.W(2), .RST_VAL(2'b01)) u_sync (
    .clk(clk), .arst_n(arst_n), .d_i({vpp_high, rst_pin_n}), .q_o(sync_q)
  );
  assign rst_s = sync_q[0];
  assign vpp_s = sync_q[1];

  psel_glitch_filter #(.FILT_LEN(FILT_LEN)) u_filt (
    .clk(clk), .arst_n(arst_n), .din_i(vpp_s), .rise_o(rise)
  );

  assign count_en  = !rst_s && prog_en;
  assign count_clr = rst_s || !prog_en;

  psel_pulse_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .arst_n(arst_n), .clr_i(count_clr), .en_i(count_en),
    .inc_i(rise), .cnt_o(pulse_cnt)
  );

  psel_mode_decode #(.CNT_W(CNT_W)) u_dec (
    .cnt_i(pulse_cnt), .mode_o(dec_mode), .legal_o(dec_legal),
    .chan_sel_o(dec_chan), .gpio_sel_o(dec_gpio)
  );

  assign release_edge = rst_s && !rst_prev_q;
  assign assert_edge  = !rst_s && rst_prev_q;

  always_comb begin
    mode_d  = mode_q;
    valid_d = valid_q;
    error_d = error_q;
    chan_d  = chan_q;
    gpio_d  = gpio_q;
    if (assert_edge) begin
      mode_d  = BM_NONE;
      valid_d = 1'b0;
      error_d = 1'b0;
      chan_d  = '0;
      gpio_d  = 1'b0;
    end else if (release_edge && prog_en) begin
      mode_d  = dec_mode;
      valid_d = dec_legal;
      error_d = !dec_legal;
      chan_d  = dec_chan;
      gpio_d  = dec_gpio;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      rst_prev_q <= 1'b1;
      mode_q     <= BM_NONE;
      valid_q    <= 1'b0;
      error_q    <= 1'b0;
      chan_q     <= '0;
      gpio_q     <= 1'b0;
    end else begin
      rst_prev_q <= rst_s;
      mode_q     <= mode_d;
      valid_q    <= valid_d;
      error_q    <= error_d;
      chan_q     <= chan_d;
      gpio_q     <= gpio_d;
    end
  end

  assign mode_o       = mode_q;
  assign mode_valid_o = valid_q;
  assign mode_error_o = error_q;
  assign chan_sel_o   = chan_q;
  assign gpio_sel_o   = gpio_q;

endmodule

// File: rtl/prog_iface_select_chk.sv
module prog_iface_select_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             arst_n,
  input logic [2:0]       mode_o,
  input logic             mode_valid_o,
  input logic             mode_error_o,
  input logic [2:0]       chan_sel_o,
  input logic             gpio_sel_o,
  input logic [CNT_W-1:0] pulse_cnt,
  input logic             count_en
);

  localparam logic [CNT_W-1:0] CMAX = '1;

  assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (!arst_n)
    !(mode_valid_o && mode_error_o));

  assert_valid_has_mode_R2: assert property (@(posedge clk) disable iff (!arst_n)
    mode_valid_o |-> (mode_o != 3'd7));

  assert_error_clean_R3: assert property (@(posedge clk) disable iff (!arst_n)
    mode_error_o |-> (mode_o == 3'd7 && chan_sel_o == '0 && !gpio_sel_o));

  assert_chan_onehot_R7: assert property (@(posedge clk) disable iff (!arst_n)
    $onehot0(chan_sel_o) && !(gpio_sel_o && chan_sel_o != '0));

  assert_cnt_saturates_R4: assert property (@(posedge clk) disable iff (!arst_n)
    (pulse_cnt == CMAX && count_en) |=> (pulse_cnt == CMAX || pulse_cnt == '0));

  assert_cnt_steps_R1: assert property (@(posedge clk) disable iff (!arst_n)
    (pulse_cnt != $past(pulse_cnt)) |->
      (pulse_cnt == '0 || pulse_cnt == $past(pulse_cnt) + 1'b1));

endmodule

bind prog_iface_select prog_iface_select_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .arst_n(arst_n), .mode_o(mode_o), .mode_valid_o(mode_valid_o),
  .mode_error_o(mode_error_o), .chan_sel_o(chan_sel_o), .gpio_sel_o(gpio_sel_o),
  .pulse_cnt(pulse_cnt), .count_en(count_en)
);

// File: tb/prog_iface_select_test.sv
module prog_iface_select_test;

  logic       clk = 1'b0;
  logic       arst_n, rst_pin_n, vpp_high, prog_en;
  logic [2:0] mode_o, chan_sel_o;
  logic       mode_valid_o, mode_error_o, gpio_sel_o;
  int         n_chk = 0, n_bad = 0;
  bit         done = 0;

  always #4 clk = ~clk;

  prog_iface_select uut (
    .clk(clk), .arst_n(arst_n), .rst_pin_n(rst_pin_n), .vpp_high(vpp_high),
    .prog_en(prog_en), .mode_o(mode_o), .mode_valid_o(mode_valid_o),
    .mode_error_o(mode_error_o), .chan_sel_o(chan_sel_o), .gpio_sel_o(gpio_sel_o)
  );

  function automatic logic [2:0] exp_mode(int k);
    case (k)
      0: return 3'd0;  1: return 3'd1;  2: return 3'd2;  4: return 3'd3;
      8: return 3'd4;  9: return 3'd5; 12: return 3'd6;
      default: return 3'd7;
    endcase
  endfunction

  function automatic logic [2:0] exp_chan(logic [2:0] m);
    case (m)
      3'd0, 3'd3: return 3'b001;
      3'd1, 3'd4: return 3'b010;
      3'd2, 3'd5: return 3'b100;
      default:    return 3'b000;
    endcase
  endfunction

  task automatic chk(string req, int got, int exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic chk_all(string req, logic [2:0] m, logic v, logic e);
    chk({req, " mode"},  mode_o,       m);
    chk({req, " valid"}, mode_valid_o, v);
    chk({req, " error"}, mode_error_o, e);
    chk({req, " chan"},  chan_sel_o,   (v ? exp_chan(m) : 3'b000));
    chk({req, " gpio"},  gpio_sel_o,   (v && m == 3'd6));
  endtask

  task automatic pulse(int w);
    vpp_high = 1'b1;
    repeat (w) @(negedge clk);
    vpp_high = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic enter(logic en);
    rst_pin_n = 1'b0;
    prog_en   = en;
    repeat (6) @(negedge clk);
  endtask

  task automatic leave;
    repeat (10) @(negedge clk);
    rst_pin_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    arst_n = 1'b0; rst_pin_n = 1'b1; vpp_high = 1'b0; prog_en = 1'b0;
    repeat (3) @(negedge clk);
    chk_all("R9 reset state", 3'd7, 1'b0, 1'b0);
    arst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Sweep every count 0..16: legal map (R2), others error (R3), saturation (R4)
    for (int k = 0; k <= 16; k++) begin
      logic [2:0] m;
      m = exp_mode(k);
      enter(1'b1);
      chk_all("R6 cleared on reset entry", 3'd7, 1'b0, 1'b0);
      for (int p = 0; p < k; p++) pulse(6);
      leave();
      if (k >= 15)      chk_all("R4 saturated count", 3'd7, 1'b0, 1'b1);
      else if (m != 7)  chk_all("R2 legal count", m, 1'b1, 1'b0);
      else              chk_all("R3 illegal count", 3'd7, 1'b0, 1'b1);
      chk_all("R7 select mapping", m, (m != 7), (m == 7));
    end

    // R1: glitches shorter than 4 clocks are dropped; exactly 4 counts
    enter(1'b1);
    pulse(6); pulse(3); pulse(3); pulse(4);
    leave();
    chk_all("R1 glitch filter", 3'd2, 1'b1, 1'b0);

    enter(1'b1);
    pulse(3); pulse(2); pulse(1);
    leave();
    chk_all("R1 only short pulses", 3'd0, 1'b1, 1'b0);

    // R5: pulses after release do not disturb the latched result
    enter(1'b1);
    repeat (4) pulse(5);
    leave();
    chk_all("R5 latched", 3'd3, 1'b1, 1'b0);
    repeat (5) pulse(6);
    chk_all("R5 held after release", 3'd3, 1'b1, 1'b0);

    // R8: programming entry disabled
    enter(1'b0);
    repeat (8) pulse(6);
    leave();
    chk_all("R8 entry disabled", 3'd7, 1'b0, 1'b0);

    // R6: each reset period counts from zero
    enter(1'b1);
    pulse(6);
    leave();
    chk_all("R6 fresh count", 3'd1, 1'b1, 1'b0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule